// File: doc/BRIEF.md
# Pin Edge Interrupt Unit

This unit watches a bank of general-purpose input pins and records selected signal transitions as pending interrupt events. Each pin can be set to respond to low-to-high changes, high-to-low changes, both, or neither. A detected transition sets a sticky pending bit. That bit stays set until software clears it by writing a one to it. Each pin is brought into the clock domain through a two-stage synchronizer. A transition is found by comparing the synchronized level with the level of the cycle before.

A small word-addressed register bus gives access to three registers:

| Word address | Register | Access |
|---|---|---|
| 0 | rising enable | read/write |
| 1 | falling enable | read/write |
| 2 | pending status | read, write one to clear |
| 3 | none | reads zero |

The eleven lowest pins each drive a dedicated interrupt line. The remaining seventeen pins (11 to 27) share one line, which is the OR of their pending bits. A handler reads the pending register and masks it with 0xFFFFF800 to find which of those pins fired.

Top module: `edgeIrqUnit`

## Requirements
- R1: After reset, both enable registers and the pending register read zero, and every interrupt output is low.
- R2: With only the rising enable bit set for a pin, a 0-to-1 change on the pin sets its pending bit, and a 1-to-0 change does not.
- R3: With only the falling enable bit set for a pin, a 1-to-0 change on the pin sets its pending bit, and a 0-to-1 change does not.
- R4: With both enable bits set, either change sets the pending bit. With both enable bits clear, no change on the pin sets it.
- R5: A write to word address 2 clears every pending bit written as 1 and leaves every bit written as 0 unchanged. Writing 0xFFFFFFFF clears all pending bits.
- R6: If a transition is detected on the clock edge where a clear write targets the same bit, the bit stays set.
- R7: irqDirect[i] equals pending bit i for i from 0 to 10.
- R8: irqShared is high exactly when any pending bit from 11 to 27 is set.
- R9: The enable registers read back the written value in bits 27:0. Bits 31:28 of all registers read zero and ignore writes. Word address 3 reads zero.
- R10: After a pin changes, its pending bit is set on the third rising clock edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 28 | Asynchronous pin levels |
| busEn | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Word address: 0 rising enable, 1 falling enable, 2 pending |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from the address |
| irqDirect | output | 11 | Per-pin interrupt lines for pins 0 to 10 |
| irqShared | output | 1 | Combined interrupt line for pins 11 to 27 |

## Verification
Directed cases drive each pin polarity against each enable combination. These cases separate a unit that swaps the two edge senses from one that ignores either enable. A timed case checks the pending bit one edge before and at the third edge, which catches a missing or extra synchronizer stage. A clear write that lands on the same edge as a new transition shows whether clear wins over set. Random pin patterns, random enable values and random partial clears are then compared against a bench model of the pending register. The model covers both the shared line and the direct lines, which exposes errors in bit mapping and in the OR across the upper group.

// File: rtl/edgeIrqPkg.sv
package edgeIrqPkg;
  typedef enum logic [1:0] {
    SEL_RISE = 2'd0,
    SEL_FALL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrRise;
    logic    wrFall;
    logic    wrClr;
    regSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/edgeIrqCtrl.sv
module edgeIrqCtrl
  import edgeIrqPkg::*;
(
  input  logic        busEn,
  input  logic        busWr,
  input  logic [1:0]  busAddr,
  output ctrlStrobe_t strobe
);
  regSel_e sel;

  always_comb begin
    case (busAddr)
      2'd0:    sel = SEL_RISE;
      2'd1:    sel = SEL_FALL;
      2'd2:    sel = SEL_STAT;
      default: sel = SEL_NONE;
    endcase
    strobe.wrRise = busEn && busWr && (sel == SEL_RISE);
    strobe.wrFall = busEn && busWr && (sel == SEL_FALL);
    strobe.wrClr  = busEn && busWr && (sel == SEL_STAT);
    strobe.rdSel  = sel;
  end
endmodule

// File: rtl/edgeIrqPath.sv
module edgeIrqPath
  import edgeIrqPkg::*;
#(
  parameter int NUM_PINS    = 28,
  parameter int NUM_DIRECT  = 11,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  ctrlStrobe_t           strobe,
  input  logic [NUM_PINS-1:0]   wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic [NUM_DIRECT-1:0] irqDirect,
  output logic                  irqShared,
  output logic [NUM_PINS-1:0]   statusQ,
  output logic [NUM_PINS-1:0]   riseEnQ,
  output logic [NUM_PINS-1:0]   fallEnQ
);
  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] levelNow;
  logic [NUM_PINS-1:0] edgeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= pinIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign levelNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= levelNow;
  end

  assign edgeHit = (levelNow & ~prevQ & riseEnQ) | (~levelNow & prevQ & fallEnQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseEnQ <= '0;
      fallEnQ <= '0;
      statusQ <= '0;
    end else begin
      if (strobe.wrRise) riseEnQ <= wrData;
      if (strobe.wrFall) fallEnQ <= wrData;
      statusQ <= (statusQ & ~(strobe.wrClr ? wrData : '0)) | edgeHit;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_RISE: rdData = DATA_W'(riseEnQ);
      SEL_FALL: rdData = DATA_W'(fallEnQ);
      SEL_STAT: rdData = DATA_W'(statusQ);
      default:  rdData = '0;
    endcase
  end

  assign irqDirect = statusQ[NUM_DIRECT-1:0];
  assign irqShared = |statusQ[NUM_PINS-1:NUM_DIRECT];
endmodule

// File: rtl/edgeIrqUnit.sv
module edgeIrqUnit
  import edgeIrqPkg::*;
#(
  parameter int NUM_PINS   = 28,
  parameter int NUM_DIRECT = 11,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic                  busEn,
  input  logic                  busWr,
  input  logic [1:0]            busAddr,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  output logic [NUM_DIRECT-1:0] irqDirect,
  output logic                  irqShared
);
  ctrlStrobe_t         strobe;
  logic [NUM_PINS-1:0] statusQ;
  logic [NUM_PINS-1:0] riseEnQ;
  logic [NUM_PINS-1:0] fallEnQ;
  logic                unusedHiBits;

  assign unusedHiBits = ^busWrData[DATA_W-1:NUM_PINS];

  edgeIrqCtrl u_ctrl (
    .busEn  (busEn),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  edgeIrqPath #(
    .NUM_PINS  (NUM_PINS),
    .NUM_DIRECT(NUM_DIRECT),
    .DATA_W    (DATA_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .strobe   (strobe),
    .wrData   (busWrData[NUM_PINS-1:0]),
    .rdData   (busRdData),
    .irqDirect(irqDirect),
    .irqShared(irqShared),
    .statusQ  (statusQ),
    .riseEnQ  (riseEnQ),
    .fallEnQ  (fallEnQ)
  );
endmodule

// File: rtl/edgeIrqChecker.sv
module edgeIrqChecker #(
  parameter int NUM_PINS   = 28,
  parameter int NUM_DIRECT = 11
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_PINS-1:0]   pinIn,
  input logic                  busEn,
  input logic                  busWr,
  input logic [1:0]            busAddr,
  input logic [NUM_DIRECT-1:0] irqDirect,
  input logic                  irqShared,
  input logic [NUM_PINS-1:0]   statusQ,
  input logic [NUM_PINS-1:0]   riseEnQ,
  input logic [NUM_PINS-1:0]   fallEnQ
);
  logic [2:0] sinceReset;
  logic       clrWrite;

  assign clrWrite = busEn && busWr && (busAddr == 2'd2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceReset <= '0;
    else if (sinceReset != 3'd5) sinceReset <= sinceReset + 3'd1;
  end

  // R1: reset empties the pending register
  p_reset_clear_r1: assert property (@(posedge clk) !rstN |=> statusQ == '0);

  // R5: pending bits only fall through a clear write
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    !clrWrite |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R4: with no enable bits, nothing new becomes pending
  p_no_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (riseEnQ == '0 && fallEnQ == '0) |=> ((statusQ & ~$past(statusQ)) == '0));

  // R7: direct lines follow the low pending bits
  p_direct_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqDirect == statusQ[NUM_DIRECT-1:0]);

  // R8: shared line reflects the upper group
  p_shared_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqShared == (statusQ[NUM_PINS-1:NUM_DIRECT] != '0));

  // R10: a newly pending bit needs a pin change exactly three edges earlier
  p_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset == 3'd5) |->
      ((statusQ & ~$past(statusQ) & ~($past(pinIn, 3) ^ $past(pinIn, 4))) == '0));
endmodule

bind edgeIrqUnit edgeIrqChecker #(
  .NUM_PINS  (NUM_PINS),
  .NUM_DIRECT(NUM_DIRECT)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pinIn    (pinIn),
  .busEn    (busEn),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .irqDirect(irqDirect),
  .irqShared(irqShared),
  .statusQ  (statusQ),
  .riseEnQ  (riseEnQ),
  .fallEnQ  (fallEnQ)
);

// File: tb/edgeIrqUnit_bench.sv
module edgeIrqUnit_bench;
  localparam int NP = 28;
  localparam logic [27:0] PMASK = 28'hFFFFFFF;

  logic        clk = 0;
  logic        rstN = 0;
  logic [27:0] pinIn = '0;
  logic        busEn = 0, busWr = 0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [10:0] irqDirect;
  logic        irqShared;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [27:0] mRise = '0, mFall = '0, mStat = '0, mPin = '0;

  always #5 clk = ~clk;

  edgeIrqUnit u_edgeIrqUnit (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busEn(busEn), .busWr(busWr),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqDirect(irqDirect), .irqShared(irqShared)
  );

  function automatic logic [27:0] edgesOf(logic [27:0] oldP, logic [27:0] newP,
                                          logic [27:0] re, logic [27:0] fe);
    return (~oldP & newP & re) | (oldP & ~newP & fe);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    busEn = 1; busWr = 1; busAddr = a; busWrData = d;
    @(negedge clk);
    busEn = 0; busWr = 0;
  endtask

  task automatic busRead(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busEn = 1; busWr = 0; busAddr = a;
    #1 d = busRdData;
    busEn = 0;
  endtask

  task automatic setRise(logic [31:0] d); busWrite(2'd0, d); mRise = d[27:0]; endtask
  task automatic setFall(logic [31:0] d); busWrite(2'd1, d); mFall = d[27:0]; endtask
  task automatic clearStat(logic [31:0] d); busWrite(2'd2, d); mStat = mStat & ~d[27:0]; endtask

  task automatic stepPins(logic [27:0] p);
    @(negedge clk);
    pinIn = p;
    mStat = mStat | edgesOf(mPin, p, mRise, mFall);
    mPin = p;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkAll(string tag);
    logic [31:0] d;
    busRead(2'd2, d);
    chk({tag, " status"}, d, {4'h0, mStat});
    chk({tag, " irqDirect R7"}, {21'd0, irqDirect}, {21'd0, mStat[10:0]});
    chk({tag, " irqShared R8"}, {31'd0, irqShared}, {31'd0, |mStat[27:11]});
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    busRead(2'd0, d); chk("R1 rise", d, 0);
    busRead(2'd1, d); chk("R1 fall", d, 0);
    busRead(2'd2, d); chk("R1 status", d, 0);
    chk("R1 irqDirect", {21'd0, irqDirect}, 0);
    chk("R1 irqShared", {31'd0, irqShared}, 0);

    // R4 no enables: toggles leave nothing pending
    stepPins(PMASK); stepPins('0); checkAll("R4 disabled");

    // R9 readback and upper bits
    setRise(32'hFFFF_FFFF); busRead(2'd0, d); chk("R9 rise upper", d, 32'h0FFF_FFFF);
    setFall(32'hA5A5_5A5A); busRead(2'd1, d); chk("R9 fall upper", d, 32'h05A5_5A5A);
    busRead(2'd3, d); chk("R9 addr3", d, 0);
    setRise(0); setFall(0);

    // R2 rising only on pin 2
    setRise(32'h4);
    stepPins(28'h4); checkAll("R2 rise");
    clearStat(32'h4);
    stepPins(28'h0); checkAll("R2 fall ignored");

    // R3 falling only on pin 20 (shared group)
    setRise(0); setFall(32'h0010_0000);
    stepPins(28'h0010_0000); checkAll("R3 rise ignored");
    stepPins(28'h0); checkAll("R3 fall");

    // R5 partial clear and write of zeros
    setRise(32'h0FFF_FFFF); setFall(0);
    stepPins(28'h0018_0003); checkAll("R5 setup");
    clearStat(32'h0); checkAll("R5 zero write");
    clearStat(32'h0010_0001); checkAll("R5 partial");
    clearStat(32'hFFFF_FFFF); checkAll("R5 all ones");

    // R10 latency on pin 3
    @(negedge clk);
    pinIn = 28'h0018_000B;
    @(negedge clk); @(negedge clk);
    chk("R10 not at edge 2", {31'd0, irqDirect[3]}, 0);
    @(negedge clk);
    chk("R10 at edge 3", {31'd0, irqDirect[3]}, 1);
    mStat = mStat | edgesOf(mPin, 28'h0018_000B, mRise, mFall);
    mPin = 28'h0018_000B;
    clearStat(32'hFFFF_FFFF);

    // R6 clear colliding with new edge on pin 5; pin 1 pending gets cleared
    stepPins(28'h0018_0009); // pin 1 falls (no fall enable)
    setFall(32'h20); stepPins(28'h0018_0029); // pin 5 rises -> pending
    stepPins(28'h0018_002B); // pin 1 rises -> pending
    @(negedge clk);
    pinIn = 28'h0018_000B; // pin 5 falls
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    busEn = 1; busWr = 1; busAddr = 2'd2; busWrData = 32'h22;
    @(negedge clk);
    busEn = 0; busWr = 0;
    mPin = 28'h0018_000B;
    mStat = (mStat & ~28'h2) | 28'h20;
    repeat (3) @(negedge clk);
    checkAll("R6 collide");
    clearStat(32'hFFFF_FFFF);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: setRise($urandom);
        1: setFall($urandom);
        2: clearStat($urandom);
        default: stepPins($urandom & PMASK);
      endcase
      checkAll("rand R2 R3 R4 R5");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 got=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule